// File: doc/BRIEF.md
# Per-pipe ready interrupt aggregator

This block gathers per-pipe interrupt events for ten data pipes in two event classes. One class signals that a pipe buffer is ready. The other signals that a pipe refused a transfer. Each class has its own enable register, with one bit per pipe, and its own sticky status register. A summary register shows which classes have status pending, and an active-low interrupt line goes to the host.

An event pulse on a pipe is latched only when that pipe's enable bit is set. A class asks for an interrupt while it has pending status and at least one of its enable bits is set. Software can therefore mask a class by clearing all of its enables. Setting any enable bit again while status is still pending pulls the line low again at once. Software clears status bits by writing zeros, and a write of one leaves a bit unchanged. Every register is reached through a single-cycle synchronous port with a 7-bit address and 16-bit data.

Top module: `pipe_irq_aggr`

## Requirements
- R1: A synchronous active-high reset clears every enable and status bit and drives `irq_n` high.
- R2: The enable registers live at address 0x36 (ready class) and 0x38 (refuse class). Bit n controls pipe n for n from 0 to 9, and both registers read back what was written.
- R3: Bits 15 to 10 of every register read as 0, and writing ones to them changes nothing.
- R4: An event pulse on a pipe whose enable bit is 1 sets that pipe's status bit at the next rising edge. Status is at 0x46 for the ready class and 0x48 for the refuse class. The class summary bit also sets and `irq_n` goes low.
- R5: An event on a pipe whose enable bit is 0 leaves that pipe's status bit at 0 and does not lower `irq_n`.
- R6: Writing a status register clears every bit written as 0 and keeps every bit written as 1.
- R7: If an event on an enabled pipe arrives in the same cycle as a write that clears that pipe's status bit, the bit ends up set.
- R8: The read-only summary register at 0x40 holds the OR of the ready-class status in bit 0 and the OR of the refuse-class status in bit 1. Writes to it are ignored.
- R9: `irq_n` is low exactly when some class has a status bit set and at least one enable bit set. Raising any enable of a class from all-zero while its status is pending lowers `irq_n` in that same cycle.
- R10: The two classes keep separate enable, status and summary state, and an event or write in one class never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 7 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, valid in the same cycle |
| ev_ready | input | 10 | One-cycle buffer-ready event per pipe |
| ev_refuse | input | 10 | One-cycle refused-transfer event per pipe |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The hardest cases to reach from the ports are collisions within a single cycle. One is a clearing status write that lands on the same edge as a new event for the same pipe. The other is an enable write that re-arms a masked class while its status is still pending. The bench drives the write strobe and the event pulse together on one falling edge to create the collision. To reach the re-arm case, it first latches status, then clears all enables of that class, checks that `irq_n` is high while the status still reads back as set, and finally writes a single enable bit.

// File: rtl/pipe_irq_pkg.sv
package pipe_irq_pkg;

    localparam int NCLS = 2;

    typedef enum logic [0:0] {
        CLS_READY  = 1'b0,
        CLS_REFUSE = 1'b1
    } evt_cls_e;

    localparam logic [6:0] ADR_EN_READY  = 7'h36;
    localparam logic [6:0] ADR_EN_REFUSE = 7'h38;
    localparam logic [6:0] ADR_SUMMARY   = 7'h40;
    localparam logic [6:0] ADR_ST_READY  = 7'h46;
    localparam logic [6:0] ADR_ST_REFUSE = 7'h48;

    typedef struct packed {
        logic en_we;
        logic st_we;
    } cls_ctl_t;

    function automatic logic [6:0] en_addr(input int c);
        return (c == int'(CLS_READY)) ? ADR_EN_READY : ADR_EN_REFUSE;
    endfunction

    function automatic logic [6:0] st_addr(input int c);
        return (c == int'(CLS_READY)) ? ADR_ST_READY : ADR_ST_REFUSE;
    endfunction

endpackage

// File: rtl/pipe_irq_class.sv
module pipe_irq_class #(
    parameter int NP = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  pipe_irq_pkg::cls_ctl_t ctl,
    input  logic [NP-1:0]        wbits,
    input  logic [NP-1:0]        ev,
    output logic [NP-1:0]        en_q,
    output logic [NP-1:0]        st_q,
    output logic                 summary,
    output logic                 irq_req
);

    logic [NP-1:0] hit;
    logic [NP-1:0] kept;

    // Latch only events of enabled pipes; a new event beats a same-cycle clear.
    assign hit  = ev & en_q;
    assign kept = ctl.st_we ? (st_q & wbits) : st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            if (ctl.en_we) begin
                en_q <= wbits;
            end
            st_q <= kept | hit;
        end
    end

    assign summary = |st_q;
    assign irq_req = summary & (|en_q);

endmodule

// File: rtl/pipe_irq_regmap.sv
module pipe_irq_regmap #(
    parameter int NP     = 10,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16,
    parameter int NC     = pipe_irq_pkg::NCLS
) (
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NC-1:0][NP-1:0]       en_q,
    input  logic [NC-1:0][NP-1:0]       st_q,
    input  logic [NC-1:0]               summary,
    output pipe_irq_pkg::cls_ctl_t [NC-1:0] ctl,
    output logic [DATA_W-1:0]           rdata
);
    import pipe_irq_pkg::*;

    for (genvar c = 0; c < NC; c++) begin : g_dec
        assign ctl[c].en_we = wr_en && (addr == ADDR_W'(en_addr(c)));
        assign ctl[c].st_we = wr_en && (addr == ADDR_W'(st_addr(c)));
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NC; c++) begin
            if (addr == ADDR_W'(en_addr(c))) rdata[NP-1:0] = en_q[c];
            if (addr == ADDR_W'(st_addr(c))) rdata[NP-1:0] = st_q[c];
        end
        if (addr == ADDR_W'(ADR_SUMMARY)) rdata[NC-1:0] = summary;
    end

endmodule

// File: rtl/pipe_irq_aggr.sv
module pipe_irq_aggr #(
    parameter int NUM_PIPES = 10,
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    input  logic [NUM_PIPES-1:0] ev_ready,
    input  logic [NUM_PIPES-1:0] ev_refuse,
    output logic                 irq_n
);
    import pipe_irq_pkg::*;

    logic [NCLS-1:0][NUM_PIPES-1:0] ev_q;
    logic [NCLS-1:0][NUM_PIPES-1:0] en_q;
    logic [NCLS-1:0][NUM_PIPES-1:0] st_q;
    logic [NCLS-1:0]                summary;
    logic [NCLS-1:0]                irq_req;
    cls_ctl_t [NCLS-1:0]            ctl;

    assign ev_q[CLS_READY]  = ev_ready;
    assign ev_q[CLS_REFUSE] = ev_refuse;

    pipe_irq_regmap #(
        .NP(NUM_PIPES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NC(NCLS)
    ) u_map (
        .wr_en(wr_en), .addr(addr), .en_q(en_q), .st_q(st_q),
        .summary(summary), .ctl(ctl), .rdata(rdata)
    );

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        pipe_irq_class #(.NP(NUM_PIPES)) u_cls (
            .clk(clk), .rst(rst), .ctl(ctl[c]),
            .wbits(wdata[NUM_PIPES-1:0]), .ev(ev_q[c]),
            .en_q(en_q[c]), .st_q(st_q[c]),
            .summary(summary[c]), .irq_req(irq_req[c])
        );
    end

    assign irq_n = ~(|irq_req);

endmodule

// File: rtl/pipe_irq_aggr_chk.sv
module pipe_irq_aggr_chk #(
    parameter int NP = 10,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [NP-1:0] ev_ready,
    input logic [NP-1:0] ev_refuse,
    input logic [NP-1:0] en_rdy,
    input logic [NP-1:0] en_ref,
    input logic [NP-1:0] st_rdy,
    input logic [NP-1:0] st_ref,
    input logic [DW-1:0] rdata,
    input logic          irq_n
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (en_rdy == '0 && en_ref == '0 && st_rdy == '0 && st_ref == '0 && irq_n));

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        rdata[DW-1:NP] == '0);

    assert_enabled_latch_R4: assert property (@(posedge clk) disable iff (rst)
        ((ev_ready & en_rdy) != '0) |=>
        ((st_rdy & $past(ev_ready & en_rdy)) == $past(ev_ready & en_rdy)));

    assert_no_spurious_ready_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((st_rdy & ~$past(st_rdy) & ~$past(ev_ready & en_rdy)) == '0));

    assert_no_spurious_refuse_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((st_ref & ~$past(st_ref) & ~$past(ev_refuse & en_ref)) == '0));

    assert_irq_low_R9: assert property (@(posedge clk) disable iff (rst)
        ((st_rdy != '0 && en_rdy != '0) || (st_ref != '0 && en_ref != '0)) |-> !irq_n);

    assert_irq_high_R9: assert property (@(posedge clk) disable iff (rst)
        ((st_rdy == '0 || en_rdy == '0) && (st_ref == '0 || en_ref == '0)) |-> irq_n);

endmodule

bind pipe_irq_aggr pipe_irq_aggr_chk #(.NP(NUM_PIPES), .DW(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .ev_ready(ev_ready), .ev_refuse(ev_refuse),
    .en_rdy(en_q[0]), .en_ref(en_q[1]), .st_rdy(st_q[0]), .st_ref(st_q[1]),
    .rdata(rdata), .irq_n(irq_n)
);

// File: tb/tb_pipe_irq_aggr.sv
module tb_pipe_irq_aggr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [9:0]  ev_ready = '0;
    logic [9:0]  ev_refuse = '0;
    logic        irq_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pipe_irq_aggr dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ev_ready(ev_ready), .ev_refuse(ev_refuse), .irq_n(irq_n)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EVA = 2'd2, OP_EVB = 2'd3;
    localparam int NV = 19;
    // {req, op, addr, data, expected rdata, expected irq_n}
    localparam logic [45:0] VEC [NV] = '{
        {4'd2,  OP_WR,  7'h36, 16'hFFFF, 16'h0000, 1'b1},
        {4'd3,  OP_RD,  7'h36, 16'h0000, 16'h03FF, 1'b1},  // R2 R3
        {4'd2,  OP_WR,  7'h38, 16'h0005, 16'h0000, 1'b1},
        {4'd2,  OP_RD,  7'h38, 16'h0000, 16'h0005, 1'b1},  // R2
        {4'd4,  OP_EVA, 7'h00, 16'h0009, 16'h0000, 1'b0},
        {4'd4,  OP_RD,  7'h46, 16'h0000, 16'h0009, 1'b0},  // R4
        {4'd8,  OP_RD,  7'h40, 16'h0000, 16'h0001, 1'b0},  // R8
        {4'd5,  OP_EVB, 7'h00, 16'h0002, 16'h0000, 1'b0},
        {4'd5,  OP_RD,  7'h48, 16'h0000, 16'h0000, 1'b0},  // R5
        {4'd4,  OP_EVB, 7'h00, 16'h0004, 16'h0000, 1'b0},
        {4'd8,  OP_RD,  7'h40, 16'h0000, 16'h0003, 1'b0},  // R8
        {4'd6,  OP_WR,  7'h46, 16'hFFF7, 16'h0000, 1'b0},
        {4'd6,  OP_RD,  7'h46, 16'h0000, 16'h0001, 1'b0},  // R6
        {4'd6,  OP_WR,  7'h46, 16'hFFFE, 16'h0000, 1'b0},
        {4'd10, OP_RD,  7'h40, 16'h0000, 16'h0002, 1'b0},  // R10
        {4'd6,  OP_WR,  7'h48, 16'h0000, 16'h0000, 1'b1},
        {4'd9,  OP_RD,  7'h40, 16'h0000, 16'h0000, 1'b1},  // R9
        {4'd8,  OP_WR,  7'h40, 16'hFFFF, 16'h0000, 1'b1},
        {4'd8,  OP_RD,  7'h40, 16'h0000, 16'h0000, 1'b1}   // R8
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [6:0] a, input logic [15:0] exp, input logic irq_exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rdata, exp);
        chk(req, {15'd0, irq_n}, {15'd0, irq_exp});
    endtask

    task automatic pulse(input logic cls, input logic [9:0] bits);
        @(negedge clk);
        if (cls) ev_refuse = bits; else ev_ready = bits;
        @(negedge clk);
        ev_ready = '0; ev_refuse = '0;
    endtask

    task automatic summary_line();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        summary_line();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd("R1", 7'h36, 16'h0000, 1'b1);
        rd("R1", 7'h46, 16'h0000, 1'b1);
        rd("R1", 7'h40, 16'h0000, 1'b1);

        for (int i = 0; i < NV; i++) begin
            logic [3:0]  req;
            logic [1:0]  op;
            logic [6:0]  a;
            logic [15:0] d, e;
            logic        q;
            {req, op, a, d, e, q} = VEC[i];
            case (op)
                OP_WR:  wr(a, d);
                OP_EVA: pulse(1'b0, d[9:0]);
                OP_EVB: pulse(1'b1, d[9:0]);
                default: rd($sformatf("R%0d vec %0d", req, i), a, e, q);
            endcase
        end

        // R3: upper bits ignored on write
        wr(7'h38, 16'hFC00);
        rd("R3", 7'h38, 16'h0000, 1'b1);

        // R7: event and clearing write on the same edge
        @(negedge clk);
        wr_en = 1'b1; addr = 7'h46; wdata = 16'h0000; ev_ready = 10'h001;
        @(negedge clk);
        wr_en = 1'b0; ev_ready = '0;
        rd("R7", 7'h46, 16'h0001, 1'b0);

        // R9: mask by clearing all enables, then re-arm with status pending
        wr(7'h36, 16'h0000);
        rd("R9 masked", 7'h46, 16'h0001, 1'b1);
        wr(7'h36, 16'h0200);
        rd("R9 rearm", 7'h46, 16'h0001, 1'b0);

        // R10: refuse-class activity leaves ready status alone
        wr(7'h38, 16'h0001);
        pulse(1'b1, 10'h001);
        rd("R10", 7'h46, 16'h0001, 1'b0);
        rd("R10", 7'h48, 16'h0001, 1'b0);

        // R1: reset with state pending
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd("R1", 7'h46, 16'h0000, 1'b1);
        rd("R1", 7'h38, 16'h0000, 1'b1);

        summary_line();
        $finish;
    end

endmodule